// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block forms the word a multi-bank flash returns on a read while an embedded program or erase is under way. Each bank has its own operating mode, given from outside as a three-bit code. A read names a bank and a sector. If the bank is busy, or the read hits a sector that is suspended for erase, the block returns a status word. Otherwise it returns the stored word from a small behavioural array.

The status word holds several bits. Bit 7 is a polling bit. Bits 6 and 2 are toggle bits, each inverting from one read strobe of that bank to the next. Bit 5 is a sticky overtime flag and bit 3 marks erase in progress. A global ready/busy output goes low while any bank is busy or holds an unacknowledged overtime. A per-bank clear strobe acknowledges the overtime, and the surrounding controller then sets the next mode.

Top module: `flash_status_gen`

## Requirements
- R1: A read strobe is answered in the following cycle: `rd_vld` is high for one cycle and `rd_data` holds the answer. A bank in mode 0 (read array) returns the array word `((bank*NSECT+sector)*29) ^ 0x5A`, truncated to DW bits.
- R2: In mode 1 (program), a read of that bank returns the following bits. Bit 7 is the inverse of `prog_data[7]`. Bit 6 is the bank's DQ6 toggle state. Bit 5 is the bank's overtime flag. Bits 3 and 2 are 0, and all other bits are 0.
- R3: In mode 2 (erase), a read of that bank returns bit 7 = 0, bit 6 = the DQ6 toggle state, bit 5 = the overtime flag, bit 3 = 1 and bit 2 = the DQ2 toggle state. All other bits are 0.
- R4: In mode 3 (erase suspended, reading), a read of a sector whose bit is set in `ers_mask` returns the following bits. Bit 7 is 1, bit 6 is the DQ6 toggle state and is not inverted by the read, bit 5 is the overtime flag and bit 2 is the DQ2 toggle state. All other bits are 0.
- R5: In mode 3, a read of a sector whose `ers_mask` bit is clear returns the array word.
- R6: In mode 4 (erase suspended, programming), a read of that bank returns bit 7 = the inverse of `prog_data[7]`, bit 6 = the DQ6 toggle state and bit 5 = the overtime flag. All other bits are 0.
- R7: A bank's DQ6 toggle inverts after each of its reads in modes 1, 2 and 4. Its DQ2 toggle inverts after each of its reads in mode 2, and after each suspended-sector read in mode 3. Reads of other banks leave both toggles unchanged, and both toggles clear to 0 on the cycle after the bank's mode code changes.
- R8: The overtime flag of a bank is set by its `tmo` bit while the bank is in mode 1, 2 or 4. It stays set until that bank's `clr_cmd` bit. A `tmo` bit of a bank in mode 0 has no effect.
- R9: `ry_by` is 0 when any bank is in mode 1, 2 or 4, or holds a set overtime flag, and is 1 otherwise.
- R10: The status word is driven only for the addressed bank. A read of a bank in mode 0 returns array data while another bank is busy.
- R11: After reset, `rd_vld` and `rd_data` are 0, `ry_by` is 1, and all toggles and overtime flags are 0. Mode codes 5 to 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_mode | input | 3*NBANK | Mode code of bank b at bits [3b+2:3b] |
| ers_mask | input | NSECT | Sectors suspended for erase, one bit each |
| prog_data | input | DW | Data word being programmed |
| tmo | input | NBANK | Overtime strobe per bank |
| clr_cmd | input | NBANK | Overtime acknowledge per bank |
| rd | input | 1 | Read strobe |
| rd_bank | input | $clog2(NBANK) | Read bank |
| rd_sect | input | $clog2(NSECT) | Read sector |
| rd_data | output | DW | Read answer |
| rd_vld | output | 1 | Read answer valid |
| ry_by | output | 1 | Ready (1) or busy (0) |

## Verification
One bank is stepped through every mode code while the bench reads each of its sectors twice and reads an idle bank in between. The repeated reads separate toggling bits from held ones. The interleaved reads show that status stays with the busy bank and that toggle state is kept per bank. The suspend modes run with alternating bits set in `ers_mask`, which separates the suspended-sector reads from the array reads. Overtime strobes are sent to a busy bank and to an idle bank, then acknowledged, to show that the flag is sticky and that an idle bank ignores the strobe.

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
  parameter int NBANK = 4,
  parameter int NSECT = 4,
  parameter int DW    = 8,
  localparam int BW = $clog2(NBANK),
  localparam int SW = $clog2(NSECT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3*NBANK-1:0] bank_mode,
  input  logic [NSECT-1:0]   ers_mask,
  input  logic [DW-1:0]      prog_data,
  input  logic [NBANK-1:0]   tmo,
  input  logic [NBANK-1:0]   clr_cmd,
  input  logic               rd,
  input  logic [BW-1:0]      rd_bank,
  input  logic [SW-1:0]      rd_sect,
  output logic [DW-1:0]      rd_data,
  output logic               rd_vld,
  output logic               ry_by
);
  localparam logic [2:0] M_PROG = 3'd1, M_ERASE = 3'd2, M_SREAD = 3'd3, M_SPROG = 3'd4;

  logic [2:0]       m [NBANK];
  logic [2:0]       mode_q [NBANK];
  logic [NBANK-1:0] busy, t6, t2, ovt;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign m[b]    = bank_mode[3*b +: 3];
    assign busy[b] = (m[b] == M_PROG) || (m[b] == M_ERASE) || (m[b] == M_SPROG);
    wire   sel     = rd && (rd_bank == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[b] <= '0;
        t6[b]     <= 1'b0;
        t2[b]     <= 1'b0;
        ovt[b]    <= 1'b0;
      end else begin
        mode_q[b] <= m[b];
        if (m[b] != mode_q[b]) begin
          t6[b] <= 1'b0;
          t2[b] <= 1'b0;
        end else if (sel) begin
          if (busy[b]) t6[b] <= ~t6[b];
          if (m[b] == M_ERASE || (m[b] == M_SREAD && ers_mask[rd_sect])) t2[b] <= ~t2[b];
        end
        if (clr_cmd[b])              ovt[b] <= 1'b0;
        else if (tmo[b] && busy[b])  ovt[b] <= 1'b1;
      end
    end

    AST_OVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovt[b] && !clr_cmd[b] |=> ovt[b]); // R8
    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (m[b] == mode_q[b]) && !sel |=> $stable(t6[b]) && $stable(t2[b])); // R7
  end

  wire [2:0] cm  = m[rd_bank];
  wire       hit = busy[rd_bank] || (cm == M_SREAD && ers_mask[rd_sect]);
  wire [DW-1:0] arr = DW'(((int'(rd_bank) * NSECT + int'(rd_sect)) * 29) ^ 32'h5A);

  logic [DW-1:0] st;
  always_comb begin
    st    = '0;
    st[6] = t6[rd_bank];
    st[5] = ovt[rd_bank];
    case (cm)
      M_PROG, M_SPROG: st[7] = ~prog_data[7];
      M_ERASE: begin st[3] = 1'b1; st[2] = t2[rd_bank]; end
      M_SREAD: begin st[7] = 1'b1; st[2] = t2[rd_bank]; end
      default: st = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd;
      if (rd) rd_data <= hit ? st : arr;
    end
  end

  assign ry_by = ~|(busy | ovt);

  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rd_vld); // R1
  AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rd_vld |-> $past(rd)); // R1
  AST_ERASE_DQ3: assert property (@(posedge clk) disable iff (!rst_n)
    rd && cm == M_ERASE |=> rd_data[3]); // R3
  AST_SREAD_DQ7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && cm == M_SREAD && ers_mask[rd_sect] |=> rd_data[7] && !rd_data[3]); // R4
endmodule

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;
  localparam int NB = 4, NS = 4, DW = 8;
  logic clk = 0, rst_n = 0;
  logic [3*NB-1:0] bank_mode = '0;
  logic [NS-1:0] ers_mask = '0;
  logic [DW-1:0] prog_data = '0;
  logic [NB-1:0] tmo = '0, clr_cmd = '0;
  logic rd = 0;
  logic [1:0] rd_bank = '0, rd_sect = '0;
  logic [DW-1:0] rd_data;
  logic rd_vld, ry_by;
  int errors = 0, checks = 0;
  int bm[NB];
  bit t6[NB], t2[NB], ov[NB];

  flash_status_gen #(.NBANK(NB), .NSECT(NS), .DW(DW)) u_flash_status_gen (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit busy_m(int md);
    return md == 1 || md == 2 || md == 4;
  endfunction

  function automatic logic [DW-1:0] arr(int b, int s);
    return DW'(((b * NS + s) * 29) ^ 90);
  endfunction

  function automatic bit exp_ry();
    for (int b = 0; b < NB; b++) if (busy_m(bm[b]) || ov[b]) return 0;
    return 1;
  endfunction

  task automatic set_mode(int b, int md);
    @(negedge clk);
    bank_mode[3*b +: 3] = 3'(md);
    bm[b] = md;
    @(negedge clk);
    @(negedge clk);
    t6[b] = 0; t2[b] = 0;
  endtask

  task automatic do_read(int b, int s, string req);
    logic [DW-1:0] e;
    bit hit;
    int md = bm[b];
    hit = busy_m(md) || (md == 3 && ers_mask[s]);
    e = '0;
    if (!hit) e = arr(b, s);
    else begin
      e[6] = t6[b]; e[5] = ov[b];
      if (md == 1 || md == 4) e[7] = ~prog_data[7];
      if (md == 2) begin e[3] = 1; e[2] = t2[b]; end
      if (md == 3) begin e[7] = 1; e[2] = t2[b]; end
    end
    @(negedge clk);
    rd = 1; rd_bank = 2'(b); rd_sect = 2'(s);
    @(negedge clk);
    rd = 0;
    chk({req, " vld"}, 32'(rd_vld), 1);
    chk(req, 32'(rd_data), 32'(e));
    if (busy_m(md)) t6[b] = ~t6[b];
    if (md == 2 || (md == 3 && ers_mask[s])) t2[b] = ~t2[b];
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin bm[b] = 0; t6[b] = 0; t2[b] = 0; ov[b] = 0; end
    #35;
    chk("R11 rd_vld", 32'(rd_vld), 0);
    chk("R11 rd_data", 32'(rd_data), 0);
    chk("R11 ry_by", 32'(ry_by), 1);
    rst_n = 1;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++) do_read(b, s, "R1 array read");
    @(negedge clk); chk("R1 vld one cycle", 32'(rd_vld), 0);

    ers_mask = 4'b0101;
    for (int md = 0; md < 8; md++) begin
      prog_data = 8'(md * 37 + ((md & 1) ? 8'h80 : 0));
      set_mode(2, md);
      chk("R9 ry_by", 32'(ry_by), 32'(exp_ry()));
      for (int s = 0; s < NS; s++) begin
        for (int k = 0; k < 2; k++)
          do_read(2, s, md == 1 ? "R2 program" : md == 2 ? "R3 erase" :
                        md == 3 ? (ers_mask[s] ? "R4 suspended sector" : "R5 other sector") :
                        md == 4 ? "R6 suspend program" : "R11 idle code");
        do_read(0, s, "R10 idle bank");
      end
    end

    set_mode(1, 2);
    set_mode(3, 1);
    for (int k = 0; k < 3; k++) begin
      do_read(1, k, "R7 bank1 toggle");
      do_read(3, k, "R7 bank3 toggle");
      do_read(1, 3, "R7 bank1 toggle again");
    end

    @(negedge clk); tmo[1] = 1; @(negedge clk); tmo[1] = 0; ov[1] = 1;
    do_read(1, 0, "R8 overtime set");
    @(negedge clk); @(negedge clk);
    do_read(1, 2, "R8 overtime held");
    set_mode(1, 0);
    chk("R9 overtime keeps busy", 32'(ry_by), 0);
    set_mode(3, 0);
    chk("R8 still busy", 32'(ry_by), 0);
    @(negedge clk); clr_cmd[1] = 1; @(negedge clk); clr_cmd[1] = 0; ov[1] = 0;
    chk("R9 ready after clear", 32'(ry_by), 1);
    @(negedge clk); tmo[0] = 1; @(negedge clk); tmo[0] = 0;
    chk("R8 idle bank ignores tmo", 32'(ry_by), 1);
    set_mode(0, 1);
    do_read(0, 1, "R8 no stale overtime");
    set_mode(0, 0);
    chk("R9 ready", 32'(ry_by), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule